// File: doc/BRIEF.md
# Variable-Latency Multiply-Accumulate Unit

This unit multiplies two operands and, on request, adds the product into a 64-bit accumulator. The accumulator is split into a high and a low 32-bit half, and both halves are always visible as outputs. It handles four operations: 16×16 multiply, 16×16 multiply-accumulate, 32×32 multiply and 32×32 multiply-accumulate. A signed/unsigned select decides how the operands are extended.

All four operations share one iterative datapath. Each cycle it forms the product of the extended first operand and one 17-bit slice of the second operand. A 32-bit operation whose second operand fits in 16 bits needs only one slice. Otherwise it takes a second pass for the upper half. The cycle count therefore depends on operand width, on the value of the second operand, and on whether accumulation is requested.

A caller pulses `start` with the operation, the mode and the operands, then waits for `done`. While `busy` is high, further starts are dropped. A one-cycle `acc_clr` zeroes the accumulator at any time.

Top module: `mac_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and both accumulator halves read zero.
- R2: Opcode 0 (16-bit multiply) multiplies bits 15:0 of both operands and writes the 32-bit product into the low half. The high half is unchanged. `done` rises one clock edge after the edge that accepts the start.
- R3: Opcode 1 (16-bit accumulate) adds the 16×16 product, extended to 64 bits, to the 64-bit accumulator. The sum wraps modulo 2^64. `done` rises two edges after acceptance.
- R4: Opcode 2 (32-bit multiply) writes the full 64-bit product into both halves, with the high half holding bits 63:32.
- R5: Opcode 3 (32-bit accumulate) adds the 64-bit product to the accumulator, wrapping modulo 2^64.
- R6: For opcodes 2 and 3, `done` rises two edges after acceptance when the second operand's bits 31:16 all equal its bit 15 (signed mode) or are all zero (unsigned mode). Otherwise it rises three edges after acceptance.
- R7: When `signed_mode` is 1, both operands are sign-extended from their operating width. When it is 0, both are zero-extended. For 16-bit opcodes, bits 31:16 of the operands have no effect.
- R8: `busy` is high from the edge that accepts a start until the edge that raises `done`. `done` is a single-cycle pulse during which `busy` is low.
- R9: A start seen while `busy` is high is ignored: the running operation finishes with its own operands and timing, and no further operation follows.
- R10: `acc_clr` zeroes both halves at the next edge. It wins over a start in the same cycle, which is then not accepted. It also wins over a result write-back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin an operation |
| opcode | input | 2 | Operation: 0 mul16, 1 mac16, 2 mul32, 3 mac32 |
| signed_mode | input | 1 | 1 sign-extends operands, 0 zero-extends them |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_clr | input | 1 | Zero both accumulator halves |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that `start`, `acc_clr` and `opcode` are never unknown once reset is released. They also assume that operands only matter in the cycle a start is accepted, since the unit latches them then. The stimulus changes every input one time unit after a rising edge and keeps each one at a known value from time zero. Operands for random operations are drawn so that both short and long second-operand forms occur in both modes. Clears and mid-operation starts are applied only in directed sequences whose timing the bench controls.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MUL16 = 2'd0,
    OP_MAC16 = 2'd1,
    OP_MUL32 = 2'd2,
    OP_MAC32 = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } mac_st_e;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           acc_clr,
  input  mac_op_e        opcode,
  input  logic           signed_mode,
  input  logic [OPW-1:0] op_b,
  output mac_st_e        state,
  output mac_op_e        op_q,
  output logic           long_q,
  output logic           busy,
  output logic           done,
  output logic           load
);
  localparam int HALF = OPW / 2;

  mac_st_e state_n;
  logic    done_n;
  logic    short_b;
  logic    long_n;

  assign busy    = (state != ST_IDLE);
  assign load    = start & ~busy & ~acc_clr;
  assign short_b = signed_mode ? (op_b[OPW-1:HALF] == {HALF{op_b[HALF-1]}})
                               : (op_b[OPW-1:HALF] == '0);
  assign long_n  = opcode[1] & ~short_b;

  always_comb begin
    state_n = state;
    done_n  = 1'b0;
    unique case (state)
      ST_IDLE: if (load) state_n = ST_LO;
      ST_LO: begin
        if (op_q == OP_MUL16) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end else if (long_q) begin
          state_n = ST_HI;
        end else begin
          state_n = ST_FIN;
        end
      end
      ST_HI:   state_n = ST_FIN;
      ST_FIN: begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      op_q   <= OP_MUL16;
      long_q <= 1'b0;
    end else begin
      state <= state_n;
      done  <= done_n;
      if (load) begin
        op_q   <= opcode;
        long_q <= long_n;
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(long_q))); // R9
  AST_MUL16_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && opcode == OP_MUL16) |=> ##1 done); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_HI_THEN_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HI) |=> (state == ST_FIN)); // R6

endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import mac_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  mac_op_e           opcode,
  input  logic              signed_mode,
  input  logic [OPW-1:0]    op_a,
  input  logic [OPW-1:0]    op_b,
  input  mac_st_e           state,
  input  logic              long_q,
  output logic [2*OPW-1:0]  prod,
  output logic [OPW-1:0]    pp_low
);
  localparam int HALF = OPW / 2;
  localparam int AW   = OPW + 1;
  localparam int CW   = HALF + 1;
  localparam int PPW  = AW + CW;
  localparam int ACCW = 2 * OPW;

  logic signed [AW-1:0]   a_q, a_ext;
  logic        [OPW-1:0]  b_q;
  logic                   sm_q;
  logic signed [CW-1:0]   chunk;
  logic signed [PPW-1:0]  pp;
  logic        [ACCW-1:0] pp_ext;
  logic        [ACCW-1:0] prod_n;
  logic                   prod_en;

  assign a_ext = opcode[1] ? {signed_mode & op_a[OPW-1], op_a}
                           : {{(HALF+1){signed_mode & op_a[HALF-1]}}, op_a[HALF-1:0]};

  always_comb begin
    if (state == ST_HI)
      chunk = {sm_q & b_q[OPW-1], b_q[OPW-1:HALF]};
    else if (long_q)
      chunk = {1'b0, b_q[HALF-1:0]};
    else
      chunk = {sm_q & b_q[HALF-1], b_q[HALF-1:0]};
  end

  assign pp     = a_q * chunk;
  assign pp_ext = {{(ACCW-PPW){pp[PPW-1]}}, pp};
  assign pp_low = pp_ext[OPW-1:0];

  assign prod_en = (state == ST_LO) || (state == ST_HI);
  assign prod_n  = (state == ST_HI) ? (prod + (pp_ext << HALF)) : pp_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      sm_q <= 1'b0;
      prod <= '0;
    end else begin
      if (load) begin
        a_q  <= a_ext;
        b_q  <= op_b;
        sm_q <= signed_mode;
      end
      if (prod_en) prod <= prod_n;
    end
  end

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(a_q) && $stable(b_q) && $stable(sm_q))); // R9

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int OPW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_clr,
  input  logic              wr_half,
  input  logic              wr_full,
  input  logic              accumulate,
  input  logic [2*OPW-1:0]  prod,
  input  logic [OPW-1:0]    pp_low,
  output logic [OPW-1:0]    acc_hi,
  output logic [OPW-1:0]    acc_lo
);
  localparam int ACCW = 2 * OPW;

  logic [ACCW-1:0] acc_q, acc_n;
  logic            acc_en;

  assign acc_en = acc_clr | wr_full | wr_half;

  always_comb begin
    if (acc_clr)
      acc_n = '0;
    else if (wr_full)
      acc_n = prod + (accumulate ? acc_q : '0);
    else
      acc_n = {acc_q[ACCW-1:OPW], pp_low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_n;
  end

  assign acc_hi = acc_q[ACCW-1:OPW];
  assign acc_lo = acc_q[OPW-1:0];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> (acc_hi == '0 && acc_lo == '0)); // R10
  AST_HALF_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_half && !acc_clr) |=> $stable(acc_hi)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> ($stable(acc_hi) && $stable(acc_lo))); // R9

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     opcode,
  input  logic           signed_mode,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic           acc_clr,
  output logic [OPW-1:0] acc_hi,
  output logic [OPW-1:0] acc_lo,
  output logic           busy,
  output logic           done
);
  localparam int ACCW = 2 * OPW;

  logic            rst_meta_n, rst_sync_n;
  mac_st_e         state;
  mac_op_e         op_q;
  mac_op_e         op_in;
  logic            long_q, load;
  logic [ACCW-1:0] prod;
  logic [OPW-1:0]  pp_low;
  logic            wr_half, wr_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign op_in   = mac_op_e'(opcode);
  assign wr_half = (state == ST_LO) && (op_q == OP_MUL16);
  assign wr_full = (state == ST_FIN);

  mac_ctrl #(.OPW(OPW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .acc_clr(acc_clr),
    .opcode(op_in), .signed_mode(signed_mode), .op_b(op_b),
    .state(state), .op_q(op_q), .long_q(long_q),
    .busy(busy), .done(done), .load(load)
  );

  mac_dp #(.OPW(OPW)) u_dp (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .opcode(op_in),
    .signed_mode(signed_mode), .op_a(op_a), .op_b(op_b),
    .state(state), .long_q(long_q), .prod(prod), .pp_low(pp_low)
  );

  mac_acc #(.OPW(OPW)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .acc_clr(acc_clr),
    .wr_half(wr_half), .wr_full(wr_full), .accumulate(op_q[0]),
    .prod(prod), .pp_low(pp_low), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> busy); // R8
  AST_CLEAR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_clr && !busy) |=> !busy); // R10

endmodule

// File: tb/mac_unit_test.sv
`timescale 1ns/100ps
module mac_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opcode = 2'd0;
  logic        signed_mode = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        acc_clr = 1'b0;
  logic [31:0] acc_hi, acc_lo;
  logic        busy, done;

  int checks = 0;
  int failures = 0;
  logic [63:0] m_acc = '0;

  always #2.5 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .signed_mode(signed_mode), .op_a(op_a), .op_b(op_b), .acc_clr(acc_clr),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] op, input logic sm,
                                           input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb;
    if (op[1]) begin
      ea = sm ? {{32{a[31]}}, a} : {32'b0, a};
      eb = sm ? {{32{b[31]}}, b} : {32'b0, b};
    end else begin
      ea = sm ? {{48{a[15]}}, a[15:0]} : {48'b0, a[15:0]};
      eb = sm ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
    end
    return ea * eb;
  endfunction

  function automatic int ref_lat(input logic [1:0] op, input logic sm, input logic [31:0] b);
    bit short_b;
    if (op == 2'd0) return 1;
    if (op == 2'd1) return 2;
    short_b = sm ? (b[31:16] == {16{b[15]}}) : (b[31:16] == 16'h0);
    return short_b ? 2 : 3;
  endfunction

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] ref_update(input logic [63:0] acc, input logic [1:0] op,
                                             input logic [63:0] p);
    case (op)
      2'd0: return {acc[63:32], p[31:0]};
      2'd2: return p;
      default: return acc + p;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic sm,
                        input logic [31:0] a, input logic [31:0] b);
    int n;
    int lat;
    logic [63:0] p;
    p   = ref_prod(op, sm, a, b);
    lat = ref_lat(op, sm, b);
    @(posedge clk); #1;
    start = 1'b1; opcode = op; signed_mode = sm; op_a = a; op_b = b;
    @(posedge clk); #1;
    start = 1'b0; op_a = $urandom; op_b = $urandom; signed_mode = ~sm;
    check(busy === 1'b1 && done === 1'b0, "R8", "busy after accept", {62'b0, busy, done}, 64'h2);
    n = 0;
    while (n < 8) begin
      @(posedge clk); #1;
      n++;
      if (done === 1'b1) break;
      check(busy === 1'b1, "R8", "busy held", {63'b0, busy}, 64'h1);
    end
    check(n == lat, (op[1] ? "R6" : req_of(op)), "latency", 64'(n), 64'(lat));
    check(busy === 1'b0, "R8", "busy low with done", {63'b0, busy}, 64'h0);
    m_acc = ref_update(m_acc, op, p);
    check({acc_hi, acc_lo} === m_acc, req_of(op), "accumulator", {acc_hi, acc_lo}, m_acc);
    @(posedge clk); #1;
    check(done === 1'b0, "R8", "done pulse", {63'b0, done}, 64'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h1, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check(busy === 1'b0 && done === 1'b0, "R1", "status in reset", {62'b0, busy, done}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check({acc_hi, acc_lo} === 64'h0, "R1", "accumulator after reset", {acc_hi, acc_lo}, 64'h0);
    check(busy === 1'b0 && done === 1'b0, "R1", "status after reset", {62'b0, busy, done}, 64'h0);

    // R2 / R7: upper operand bits must not matter, high half kept
    run_op(2'd2, 1'b0, 32'h1234_5678, 32'h9abc_def0);
    run_op(2'd0, 1'b1, 32'hdead_8001, 32'hbeef_7fff);
    run_op(2'd0, 1'b0, 32'h0000_ffff, 32'h5555_ffff);
    // R3 with signed wrap
    run_op(2'd1, 1'b1, 32'h0000_8000, 32'h0000_8000);
    run_op(2'd1, 1'b1, 32'h0000_ffff, 32'h0000_0001);
    // R6 boundaries on second operand
    run_op(2'd2, 1'b1, 32'h8000_0000, 32'h0000_7fff);
    run_op(2'd2, 1'b1, 32'h8000_0000, 32'h0000_8000);
    run_op(2'd2, 1'b1, 32'h7fff_ffff, 32'hffff_8000);
    run_op(2'd2, 1'b0, 32'hffff_ffff, 32'hffff_8000);
    run_op(2'd2, 1'b0, 32'hffff_ffff, 32'h0000_ffff);
    // R5 wrap of the 64-bit sum
    run_op(2'd3, 1'b0, 32'hffff_ffff, 32'hffff_ffff);
    run_op(2'd3, 1'b0, 32'hffff_ffff, 32'hffff_ffff);
    run_op(2'd3, 1'b1, 32'h8000_0000, 32'h8000_0000);

    // R10: clear wins over a start in the same cycle
    @(posedge clk); #1;
    acc_clr = 1'b1; start = 1'b1; opcode = 2'd2; signed_mode = 1'b0;
    op_a = 32'h1111_1111; op_b = 32'h2222_2222;
    @(posedge clk); #1;
    acc_clr = 1'b0; start = 1'b0;
    m_acc = '0;
    check({acc_hi, acc_lo} === 64'h0, "R10", "clear with start", {acc_hi, acc_lo}, 64'h0);
    check(busy === 1'b0, "R10", "start not accepted", {63'b0, busy}, 64'h0);
    @(posedge clk); #1;
    check(busy === 1'b0 && done === 1'b0, "R10", "no operation after clear", {62'b0, busy, done}, 64'h0);

    // R10: clear wins over write-back of a long 32-bit accumulate
    run_op(2'd2, 1'b0, 32'h0000_0003, 32'h0000_0005);
    @(posedge clk); #1;
    start = 1'b1; opcode = 2'd3; signed_mode = 1'b0; op_a = 32'h0001_0000; op_b = 32'h0001_0000;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    acc_clr = 1'b1;
    @(posedge clk); #1;
    acc_clr = 1'b0;
    m_acc = '0;
    check(done === 1'b1, "R6", "long accumulate done", {63'b0, done}, 64'h1);
    check({acc_hi, acc_lo} === 64'h0, "R10", "clear over write-back", {acc_hi, acc_lo}, 64'h0);

    // R9: start while busy is dropped
    @(posedge clk); #1;
    start = 1'b1; opcode = 2'd2; signed_mode = 1'b1; op_a = 32'h0000_1234; op_b = 32'h0004_0003;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; opcode = 2'd0; op_a = 32'h0000_7777; op_b = 32'h0000_6666;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    m_acc = ref_prod(2'd2, 1'b1, 32'h0000_1234, 32'h0004_0003);
    check(done === 1'b1, "R9", "first op completes on time", {63'b0, done}, 64'h1);
    check({acc_hi, acc_lo} === m_acc, "R9", "first op result", {acc_hi, acc_lo}, m_acc);
    @(posedge clk); #1;
    check(busy === 1'b0, "R9", "no second op", {63'b0, busy}, 64'h0);
    @(posedge clk); #1;
    check({acc_hi, acc_lo} === m_acc && done === 1'b0, "R9", "accumulator untouched",
          {acc_hi, acc_lo}, m_acc);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  rop;
      logic        rsm;
      logic [31:0] ra, rb;
      rop = 2'($urandom_range(0, 3));
      rsm = 1'($urandom_range(0, 1));
      ra  = $urandom;
      rb  = $urandom;
      case ($urandom_range(0, 3))
        0: rb = {{16{rb[15]}}, rb[15:0]};
        1: rb = {16'h0, rb[15:0]};
        2: rb = {16'hffff, rb[15:0]};
        default: ;
      endcase
      run_op(rop, rsm, ra, rb);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule